// File: doc/BRIEF.md
# Machine Trap Entry and Return Unit

This unit holds the machine-mode trap state of a small in-order core and updates it when a trap is taken and when the core returns from one. The pipeline supplies a one-cycle trap strobe together with the PC of the trapping instruction, a cause code, a flag that marks the trap as an interrupt, and a flag that marks it as the non-maskable interrupt. The unit answers in the same cycle with a redirect target. Synchronous exceptions go to the vector base. Interrupts go to the vector base plus four times their identifier. The NMI uses identifier 31. One clock edge later the unit commits the saved PC, the cause and the interrupt-enable stack.

A return strobe redirects to the saved PC and pops the interrupt-enable stack. When an NMI is taken, the unit also copies the previous-privilege field, the previous-enable bit, the saved PC and the cause into backup registers that software cannot reach. A return from the NMI handler restores all four, so an NMI that lands inside another handler can be unwound back into that handler. The vector base and the first fetch address are both derived from a boot address whose low byte is zero. The unit does not choose which interrupt to take and does not decode instructions.

Top module: `mtrap_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no other input activity, the vector base reads as the boot address with its low byte forced to 0x00. The saved PC and the cause read 0. The status word reads 0x1800: MIE (bit 3) and MPIE (bit 7) are 0, and MPP (bits 12:11) is 2'b11.
- R2: `fetch_addr_o` always equals the upper XLEN-8 bits of `boot_addr_i` followed by a low byte of 0x80, in the same cycle.
- R3: One cycle after a trap strobe, `epc_o` holds the PC of the trapping instruction. `cause_o` holds the interrupt flag in bit XLEN-1 and the 5-bit code in bits 4:0, with all other bits zero.
- R4: One cycle after a trap strobe, MIE is 0, MPIE holds the MIE value from before the trap, and MPP is 2'b11.
- R5: A trap with neither the interrupt flag nor the NMI flag set redirects, in the same cycle, to exactly the vector base. This holds for codes 2 (illegal instruction), 3 (breakpoint), 5 (load fault), 7 (store fault) and 11 (environment call), and it holds whatever the value of MIE.
- R6: An interrupt trap with identifier N redirects, in the same cycle, to the vector base plus 4*N.
- R7: An NMI trap redirects, in the same cycle, to the vector base plus 0x7C and sets the cause to 0x8000001F, whatever cause code is presented.
- R8: A return strobe redirects, in the same cycle, to the current `epc_o`. One cycle later MIE holds the previous MPIE. Outside an NMI handler, MPIE becomes 1 and MPP becomes 2'b11.
- R9: A return strobe while an NMI handler is active restores MPP, MPIE, the saved PC and the cause to the values they held just before that NMI was taken. It then leaves the NMI state, so the next return pops normally.
- R10: A software write to the vector base stores the written value with its low 8 bits cleared, visible one cycle later.
- R11: Software writes to the saved PC and to the status word (bits 3, 7, 12:11) are visible one cycle later.
- R12: A trap strobe takes precedence over software writes to the saved PC or to the status word in the same cycle. A second trap before the handler has saved the PC overwrites the saved PC and cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_addr_i | input | XLEN | Boot address, low byte expected 0x00 |
| pc_i | input | XLEN | PC of the instruction taking the trap |
| trap_valid_i | input | 1 | Trap entry strobe |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_nmi_i | input | 1 | Trap is the non-maskable interrupt |
| trap_cause_i | input | 5 | Exception code or interrupt identifier |
| mret_i | input | 1 | Return-from-trap strobe |
| tvec_we_i | input | 1 | Software write strobe for the vector base |
| tvec_wdata_i | input | XLEN | Vector base write data |
| epc_we_i | input | 1 | Software write strobe for the saved PC |
| epc_wdata_i | input | XLEN | Saved PC write data |
| status_we_i | input | 1 | Software write strobe for the status word |
| status_wdata_i | input | XLEN | Status write data |
| redirect_valid_o | output | 1 | PC redirect requested this cycle |
| redirect_pc_o | output | XLEN | Redirect target |
| tvec_o | output | XLEN | Vector base |
| epc_o | output | XLEN | Saved PC |
| cause_o | output | XLEN | Trap cause |
| status_o | output | XLEN | Status word |
| fetch_addr_o | output | XLEN | First fetch address after reset |

## Verification
The redirect outputs and the first fetch address are combinational, so they are due in the very cycle the strobe or the boot address is applied. Every CSR change is registered once and is due one clock edge later. The bench drives each stimulus just after a falling edge. For each stimulus it queues every expected result tagged with its due cycle: the current cycle for redirect values, the next cycle for CSR values. A monitor that samples shortly after each falling edge checks only the items that are due in that cycle. Back-to-back traps, nested NMI entry and return, and traps that collide with same-cycle software writes are all scored this way.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam int unsigned CODE_W   = 5;
  localparam int unsigned NMI_ID   = 31;
  localparam int unsigned ALIGN_W  = 8;
  localparam logic [7:0]  BOOT_OFS = 8'h80;

  // status word bit positions, decoded by software
  localparam int unsigned ST_MIE   = 3;
  localparam int unsigned ST_MPIE  = 7;
  localparam int unsigned ST_MPP_L = 11;
  localparam int unsigned ST_MPP_H = 12;

  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [CODE_W-1:0] {
    EXC_ILLEGAL = 5'd2,
    EXC_BREAK   = 5'd3,
    EXC_LD_FLT  = 5'd5,
    EXC_ST_FLT  = 5'd7,
    EXC_ECALL_M = 5'd11
  } exc_code_e;

  typedef struct packed {
    logic              irq;
    logic [CODE_W-1:0] code;
  } cause_t;

endpackage

// File: rtl/mtrap_vec.sv
module mtrap_vec
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              trap_valid_i,
  input  logic              trap_irq_i,
  input  logic              trap_nmi_i,
  input  logic [CODE_W-1:0] trap_cause_i,
  input  logic              mret_i,
  input  logic [XLEN-1:0]   tvec_i,
  input  logic [XLEN-1:0]   epc_i,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o
);

  logic [CODE_W-1:0] vec_id;
  logic [XLEN-1:0]   vec_ofs;

  always_comb begin
    vec_id  = trap_nmi_i ? CODE_W'(NMI_ID) : trap_cause_i;
    vec_ofs = XLEN'(vec_id) << 2;
  end

  always_comb begin
    redirect_valid_o = trap_valid_i | mret_i;
    if (trap_valid_i) begin
      if (trap_irq_i || trap_nmi_i) begin
        redirect_pc_o = tvec_i + vec_ofs;
      end else begin
        redirect_pc_o = tvec_i;
      end
    end else begin
      redirect_pc_o = epc_i;
    end
  end

endmodule

// File: rtl/mtrap_frame.sv
module mtrap_frame
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   boot_addr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              trap_valid_i,
  input  logic              trap_irq_i,
  input  logic              trap_nmi_i,
  input  logic [CODE_W-1:0] trap_cause_i,
  input  logic              mret_i,
  input  logic              tvec_we_i,
  input  logic [XLEN-1:0]   tvec_wdata_i,
  input  logic              epc_we_i,
  input  logic [XLEN-1:0]   epc_wdata_i,
  output logic [XLEN-1:0]   tvec_o,
  output logic [XLEN-1:0]   epc_o,
  output cause_t            cause_o,
  output logic              in_nmi_o
);

  localparam int unsigned BASE_W = XLEN - ALIGN_W;

  logic [BASE_W-1:0] base_q, base_d;
  logic              base_en;
  logic [XLEN-1:0]   epc_q, epc_d, bk_epc_q, bk_epc_d;
  logic              epc_en, bk_en;
  cause_t            cause_q, cause_d, bk_cause_q, bk_cause_d;
  logic              nmi_q, nmi_d, nmi_en;
  logic [ALIGN_W-1:0] unused_low;

  assign unused_low = tvec_wdata_i[ALIGN_W-1:0] ^ boot_addr_i[ALIGN_W-1:0];

  // vector base: only the aligned upper part is stored
  always_comb begin
    base_en = tvec_we_i;
    base_d  = tvec_wdata_i[XLEN-1:ALIGN_W];
  end

  always_comb begin
    epc_d      = epc_q;
    cause_d    = cause_q;
    bk_epc_d   = epc_q;
    bk_cause_d = cause_q;
    nmi_d      = nmi_q;
    epc_en     = 1'b0;
    bk_en      = 1'b0;
    nmi_en     = 1'b0;
    if (trap_valid_i) begin
      epc_en = 1'b1;
      epc_d  = pc_i;
      if (trap_nmi_i) begin
        cause_d = '{irq: 1'b1, code: CODE_W'(NMI_ID)};
        bk_en   = 1'b1;
        nmi_en  = 1'b1;
        nmi_d   = 1'b1;
      end else begin
        cause_d = '{irq: trap_irq_i, code: trap_cause_i};
      end
    end else if (mret_i && nmi_q) begin
      epc_en  = 1'b1;
      epc_d   = bk_epc_q;
      cause_d = bk_cause_q;
      nmi_en  = 1'b1;
      nmi_d   = 1'b0;
    end else if (epc_we_i) begin
      epc_en = 1'b1;
      epc_d  = epc_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= boot_addr_i[XLEN-1:ALIGN_W];
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (epc_en) begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bk_epc_q   <= '0;
      bk_cause_q <= '0;
    end else if (bk_en) begin
      bk_epc_q   <= bk_epc_d;
      bk_cause_q <= bk_cause_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q <= 1'b0;
    end else if (nmi_en) begin
      nmi_q <= nmi_d;
    end
  end

  assign tvec_o   = {base_q, {ALIGN_W{1'b0}}};
  assign epc_o    = epc_q;
  assign cause_o  = cause_q;
  assign in_nmi_o = nmi_q;

endmodule

// File: rtl/mtrap_status.sv
module mtrap_status
  import mtrap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trap_valid_i,
  input  logic       trap_nmi_i,
  input  logic       mret_i,
  input  logic       in_nmi_i,
  input  logic       status_we_i,
  input  logic       wr_mie_i,
  input  logic       wr_mpie_i,
  input  logic [1:0] wr_mpp_i,
  output logic       mie_o,
  output logic       mpie_o,
  output logic [1:0] mpp_o
);

  logic       mie_q, mie_d, mpie_q, mpie_d;
  logic [1:0] mpp_q, mpp_d;
  logic       st_en;
  logic       bk_mpie_q, bk_mpie_d;
  logic [1:0] bk_mpp_q, bk_mpp_d;
  logic       bk_en;

  always_comb begin
    mie_d     = mie_q;
    mpie_d    = mpie_q;
    mpp_d     = mpp_q;
    st_en     = 1'b0;
    bk_mpie_d = mpie_q;
    bk_mpp_d  = mpp_q;
    bk_en     = 1'b0;
    if (trap_valid_i) begin
      st_en  = 1'b1;
      mpie_d = mie_q;
      mie_d  = 1'b0;
      mpp_d  = PRIV_M;
      bk_en  = trap_nmi_i;
    end else if (mret_i) begin
      st_en = 1'b1;
      mie_d = mpie_q;
      if (in_nmi_i) begin
        mpie_d = bk_mpie_q;
        mpp_d  = bk_mpp_q;
      end else begin
        mpie_d = 1'b1;
        mpp_d  = PRIV_M;
      end
    end else if (status_we_i) begin
      st_en  = 1'b1;
      mie_d  = wr_mie_i;
      mpie_d = wr_mpie_i;
      mpp_d  = wr_mpp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
      mpp_q  <= PRIV_M;
    end else if (st_en) begin
      mie_q  <= mie_d;
      mpie_q <= mpie_d;
      mpp_q  <= mpp_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bk_mpie_q <= 1'b0;
      bk_mpp_q  <= PRIV_M;
    end else if (bk_en) begin
      bk_mpie_q <= bk_mpie_d;
      bk_mpp_q  <= bk_mpp_d;
    end
  end

  assign mie_o  = mie_q;
  assign mpie_o = mpie_q;
  assign mpp_o  = mpp_q;

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   boot_addr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              trap_valid_i,
  input  logic              trap_irq_i,
  input  logic              trap_nmi_i,
  input  logic [CODE_W-1:0] trap_cause_i,
  input  logic              mret_i,
  input  logic              tvec_we_i,
  input  logic [XLEN-1:0]   tvec_wdata_i,
  input  logic              epc_we_i,
  input  logic [XLEN-1:0]   epc_wdata_i,
  input  logic              status_we_i,
  input  logic [XLEN-1:0]   status_wdata_i,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic [XLEN-1:0]   tvec_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   fetch_addr_o
);

  localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

  logic       in_nmi;
  cause_t     cause_s;
  logic       mie, mpie;
  logic [1:0] mpp;
  logic       unused_status;

  assign unused_status = ^status_wdata_i;

  mtrap_frame #(.XLEN(XLEN)) frame_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .boot_addr_i  (boot_addr_i),
    .pc_i         (pc_i),
    .trap_valid_i (trap_valid_i),
    .trap_irq_i   (trap_irq_i),
    .trap_nmi_i   (trap_nmi_i),
    .trap_cause_i (trap_cause_i),
    .mret_i       (mret_i),
    .tvec_we_i    (tvec_we_i),
    .tvec_wdata_i (tvec_wdata_i),
    .epc_we_i     (epc_we_i),
    .epc_wdata_i  (epc_wdata_i),
    .tvec_o       (tvec_o),
    .epc_o        (epc_o),
    .cause_o      (cause_s),
    .in_nmi_o     (in_nmi)
  );

  mtrap_status status_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trap_valid_i (trap_valid_i),
    .trap_nmi_i   (trap_nmi_i),
    .mret_i       (mret_i),
    .in_nmi_i     (in_nmi),
    .status_we_i  (status_we_i),
    .wr_mie_i     (status_wdata_i[ST_MIE]),
    .wr_mpie_i    (status_wdata_i[ST_MPIE]),
    .wr_mpp_i     (status_wdata_i[ST_MPP_H:ST_MPP_L]),
    .mie_o        (mie),
    .mpie_o       (mpie),
    .mpp_o        (mpp)
  );

  mtrap_vec #(.XLEN(XLEN)) vec_i (
    .trap_valid_i     (trap_valid_i),
    .trap_irq_i       (trap_irq_i),
    .trap_nmi_i       (trap_nmi_i),
    .trap_cause_i     (trap_cause_i),
    .mret_i           (mret_i),
    .tvec_i           (tvec_o),
    .epc_i            (epc_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o)
  );

  always_comb begin
    status_o                    = '0;
    status_o[ST_MIE]            = mie;
    status_o[ST_MPIE]           = mpie;
    status_o[ST_MPP_H:ST_MPP_L] = mpp;
  end

  assign cause_o      = {cause_s.irq, {PAD_W{1'b0}}, cause_s.code};
  assign fetch_addr_o = {boot_addr_i[XLEN-1:ALIGN_W], BOOT_OFS};

endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk
  import mtrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [XLEN-1:0]   boot_addr_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              trap_valid_i,
  input logic              trap_irq_i,
  input logic              trap_nmi_i,
  input logic [CODE_W-1:0] trap_cause_i,
  input logic              mret_i,
  input logic              tvec_we_i,
  input logic [XLEN-1:0]   tvec_wdata_i,
  input logic              epc_we_i,
  input logic [XLEN-1:0]   epc_wdata_i,
  input logic              status_we_i,
  input logic [XLEN-1:0]   status_wdata_i,
  input logic              redirect_valid_o,
  input logic [XLEN-1:0]   redirect_pc_o,
  input logic [XLEN-1:0]   tvec_o,
  input logic [XLEN-1:0]   epc_o,
  input logic [XLEN-1:0]   cause_o,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   fetch_addr_o
);

  a_r2_fetch_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o == {boot_addr_i[XLEN-1:ALIGN_W], 8'h80});

  a_r3_epc_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> epc_o == $past(pc_i));

  a_r4_enable_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> !status_o[ST_MIE] && (status_o[ST_MPIE] == $past(status_o[ST_MIE])));

  a_r5_exc_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !trap_irq_i && !trap_nmi_i) |-> redirect_valid_o && (redirect_pc_o == tvec_o));

  a_r7_nmi_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && trap_nmi_i) |-> redirect_pc_o == tvec_o + XLEN'(124));

  a_r7_nmi_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && trap_nmi_i) |=> cause_o == {1'b1, {(XLEN-6){1'b0}}, 5'd31});

  a_r8_mret_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_valid_i) |-> redirect_valid_o && (redirect_pc_o == epc_o));

  a_r8_mie_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_valid_i) |=> status_o[ST_MIE] == $past(status_o[ST_MPIE]));

  a_r10_tvec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvec_o[ALIGN_W-1:0] == '0);

  a_r12_trap_over_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && epc_we_i) |=> epc_o == $past(pc_i));

endmodule

bind mtrap_unit mtrap_unit_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/mtrap_unit_tb_top.sv
module mtrap_unit_tb_top;

  localparam int XLEN = 32;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] val;
    string       req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [XLEN-1:0]   boot_addr = 32'h0000_2000;
  logic [XLEN-1:0]   pc = '0;
  logic              trap_valid = 1'b0, trap_irq = 1'b0, trap_nmi = 1'b0;
  logic [4:0]        trap_cause = '0;
  logic              mret = 1'b0;
  logic              tvec_we = 1'b0, epc_we = 1'b0, status_we = 1'b0;
  logic [XLEN-1:0]   tvec_wdata = '0, epc_wdata = '0, status_wdata = '0;
  logic              redirect_valid;
  logic [XLEN-1:0]   redirect_pc, tvec, epc, cause, status, fetch_addr;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mtrap_unit #(.XLEN(XLEN)) dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .boot_addr_i      (boot_addr),
    .pc_i             (pc),
    .trap_valid_i     (trap_valid),
    .trap_irq_i       (trap_irq),
    .trap_nmi_i       (trap_nmi),
    .trap_cause_i     (trap_cause),
    .mret_i           (mret),
    .tvec_we_i        (tvec_we),
    .tvec_wdata_i     (tvec_wdata),
    .epc_we_i         (epc_we),
    .epc_wdata_i      (epc_wdata),
    .status_we_i      (status_we),
    .status_wdata_i   (status_wdata),
    .redirect_valid_o (redirect_valid),
    .redirect_pc_o    (redirect_pc),
    .tvec_o           (tvec),
    .epc_o            (epc),
    .cause_o          (cause),
    .status_o         (status),
    .fetch_addr_o     (fetch_addr)
  );

  localparam int S_RV = 0, S_RPC = 1, S_TVEC = 2, S_EPC = 3, S_CAUSE = 4, S_STAT = 5, S_FETCH = 6;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      S_RV:    return {31'd0, redirect_valid};
      S_RPC:   return redirect_pc;
      S_TVEC:  return tvec;
      S_EPC:   return epc;
      S_CAUSE: return cause;
      S_STAT:  return status;
      default: return fetch_addr;
    endcase
  endfunction

  // push an expected value due dly cycles from now
  task automatic expect_at(int dly, int sel, logic [31:0] v, string r);
    item_t it;
    it.due = cyc + dly;
    it.sel = sel;
    it.val = v;
    it.req = r;
    sb.push_back(it);
  endtask

  // monitor: compare due items shortly after each falling edge
  always begin
    @(negedge clk);
    #2;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] got;
      it  = sb.pop_front();
      got = observe(it.sel);
      total++;
      if (got !== it.val) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h cycle=%0d", it.req, it.sel, got, it.val, cyc);
      end
    end
  end

  task automatic idle();
    trap_valid = 0; trap_irq = 0; trap_nmi = 0; trap_cause = '0;
    mret = 0; tvec_we = 0; epc_we = 0; status_we = 0;
  endtask

  task automatic take_trap(logic irq, logic nmi, logic [4:0] code, logic [31:0] at);
    @(negedge clk);
    idle();
    trap_valid = 1; trap_irq = irq; trap_nmi = nmi; trap_cause = code; pc = at;
  endtask

  task automatic do_mret();
    @(negedge clk);
    idle();
    mret = 1;
  endtask

  task automatic wr_status(logic [31:0] v);
    @(negedge clk);
    idle();
    status_we = 1; status_wdata = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R2 fetch address
    expect_at(0, S_TVEC, 32'h0000_2000, "R1");
    expect_at(0, S_EPC, 32'h0, "R1");
    expect_at(0, S_CAUSE, 32'h0, "R1");
    expect_at(0, S_STAT, 32'h0000_1800, "R1");
    expect_at(0, S_RV, 32'h0, "R1");
    expect_at(0, S_FETCH, 32'h0000_2080, "R2");

    wr_status(32'h0000_1808);                       // R11 MIE on
    expect_at(1, S_STAT, 32'h0000_1808, "R11");

    take_trap(0, 0, 5'd2, 32'h100);                 // R5 illegal
    expect_at(0, S_RV, 32'h1, "R5");
    expect_at(0, S_RPC, 32'h0000_2000, "R5");
    expect_at(1, S_EPC, 32'h100, "R3");
    expect_at(1, S_CAUSE, 32'h2, "R3");
    expect_at(1, S_STAT, 32'h0000_1880, "R4");

    do_mret();                                      // R8
    expect_at(0, S_RPC, 32'h100, "R8");
    expect_at(1, S_STAT, 32'h0000_1888, "R8");

    take_trap(1, 0, 5'd7, 32'h104);                 // R6 timer-like id 7
    expect_at(0, S_RPC, 32'h0000_201C, "R6");
    expect_at(1, S_EPC, 32'h104, "R3");
    expect_at(1, S_CAUSE, 32'h8000_0007, "R3");
    expect_at(1, S_STAT, 32'h0000_1880, "R4");

    @(negedge clk);                                 // R10 aligned tvec write
    idle();
    tvec_we = 1; tvec_wdata = 32'h0000_30FF;
    expect_at(1, S_TVEC, 32'h0000_3000, "R10");

    take_trap(0, 1, 5'd4, 32'h300);                 // R7 NMI inside handler
    expect_at(0, S_RPC, 32'h0000_307C, "R7");
    expect_at(1, S_EPC, 32'h300, "R7");
    expect_at(1, S_CAUSE, 32'h8000_001F, "R7");
    expect_at(1, S_STAT, 32'h0000_1800, "R4");

    do_mret();                                      // R9 unwind NMI
    expect_at(0, S_RPC, 32'h300, "R9");
    expect_at(1, S_EPC, 32'h104, "R9");
    expect_at(1, S_CAUSE, 32'h8000_0007, "R9");
    expect_at(1, S_STAT, 32'h0000_1880, "R9");

    do_mret();                                      // R9 next return is ordinary
    expect_at(0, S_RPC, 32'h104, "R9");
    expect_at(1, S_STAT, 32'h0000_1888, "R9");
    expect_at(1, S_EPC, 32'h104, "R9");

    wr_status(32'h0000_0008);                       // R11 MPP field writable
    expect_at(1, S_STAT, 32'h0000_0008, "R11");
    wr_status(32'h0000_1800);
    expect_at(1, S_STAT, 32'h0000_1800, "R11");

    take_trap(0, 0, 5'd11, 32'h200);                // R5 ecall with MIE off
    expect_at(0, S_RV, 32'h1, "R5");
    expect_at(0, S_RPC, 32'h0000_3000, "R5");
    expect_at(1, S_EPC, 32'h200, "R3");
    expect_at(1, S_CAUSE, 32'd11, "R3");

    take_trap(0, 0, 5'd3, 32'h210);                 // R12 trap beats sw writes
    epc_we = 1; epc_wdata = 32'h999;
    status_we = 1; status_wdata = 32'h0000_0008;
    expect_at(0, S_RPC, 32'h0000_3000, "R5");
    expect_at(1, S_EPC, 32'h210, "R12");
    expect_at(1, S_STAT, 32'h0000_1800, "R12");

    take_trap(0, 0, 5'd5, 32'h400);                 // R12 overwrite before save
    expect_at(1, S_EPC, 32'h400, "R12");
    expect_at(1, S_CAUSE, 32'd5, "R12");
    take_trap(0, 0, 5'd7, 32'h404);
    expect_at(0, S_RPC, 32'h0000_3000, "R5");
    expect_at(1, S_EPC, 32'h404, "R12");
    expect_at(1, S_CAUSE, 32'd7, "R12");

    take_trap(1, 0, 5'd20, 32'h408);                // R6 fast id 20
    expect_at(0, S_RPC, 32'h0000_3050, "R6");
    expect_at(1, S_CAUSE, 32'h8000_0014, "R3");

    @(negedge clk);                                 // R11 saved PC write
    idle();
    epc_we = 1; epc_wdata = 32'h1234;
    expect_at(1, S_EPC, 32'h1234, "R11");
    do_mret();
    expect_at(0, S_RPC, 32'h1234, "R8");

    @(negedge clk);                                 // R2 fetch follows boot
    idle();
    boot_addr = 32'h0001_2300;
    expect_at(0, S_FETCH, 32'h0001_2380, "R2");
    expect_at(0, S_RV, 32'h0, "R2");
    expect_at(1, S_TVEC, 32'h0000_3000, "R10");

    repeat (4) @(negedge clk);
    #4;
    if (sb.size() != 0) begin
      bad++;
      total++;
      $display("FAIL scoreboard actual=%0d expected=0 items left", sb.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule